// File: doc/BRIEF.md
# Sub-word SIMD Saturating ALU

This block is a 32-bit integer arithmetic unit for a DSP data path. A per-operation lane-mode field splits each operand into one 32-bit lane, two 16-bit lanes or four 8-bit lanes. The selected operation runs on every lane independently. The operations are add, subtract, minimum, maximum and absolute value. Add, subtract, minimum and maximum each have a signed and an unsigned form.

Saturation is a persistent mode, not a per-operation encoding. A set strobe turns it on and a clear strobe turns it off. Once set, it stays in force for every later operation until it is cleared. With saturation on, out-of-range lane results clamp to the lane limits. With it off, they wrap. A per-lane flag reports each clamp or wrap.

The result and the flags are registered, so an operation presented in one cycle appears on the outputs after the next rising clock edge. All lanes share one carry-segmented adder, which is cut at lane boundaries.

Top module: `simd_sat_alu`

## Requirements
- R1: `lane_mode` selects the lane layout: 0 gives one 32-bit lane, 1 gives two 16-bit lanes and 2 gives four 8-bit lanes. Code 3 behaves as 0. Lane i occupies bits [i*W +: W]. No carry or borrow passes from one lane into the next.
- R2: `opcode` encodes the operation: 0 is add, 1 is subtract, 2 is minimum, 3 is maximum and 4 is absolute value. With saturation off, add and subtract wrap modulo 2^W per lane. Codes 5 to 7 give a zero result and zero flags.
- R3: With saturation on and `is_signed`=1, an add or subtract that leaves the lane's signed range returns the most positive value (0 followed by ones) or the most negative value (1 followed by zeros), whichever side the true result lies on.
- R4: With saturation on and `is_signed`=0, an unsigned add that carries out returns all ones. An unsigned subtract that borrows returns zero.
- R5: Minimum and maximum compare each lane as two's complement when `is_signed`=1 and as unsigned when it is 0. They never raise a flag.
- R6: A `sat_set` pulse turns saturation on and a `sat_clr` pulse turns it off. When both are high in the same cycle, clear wins. The new mode applies to operations presented from the following cycle on. An operation presented in the same cycle as a strobe uses the old mode.
- R7: `lane_ovf[i]` is 1 when lane i of the current operation was clamped, or would have been clamped, because it wrapped. The flags for lanes that do not exist in the selected mode read 0.
- R8: Absolute value always treats `src_a` as signed and ignores `src_b` and `is_signed`. For the most negative lane value it sets the flag. It then returns the most positive value when saturation is on, and returns the input unchanged when saturation is off.
- R9: `result` and `lane_ovf` update one clock edge after the operation is presented. A synchronous active-low reset clears `result`, `lane_ovf` and the saturation mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| opcode | input | 3 | Operation select (R2) |
| is_signed | input | 1 | 1 selects the signed form |
| lane_mode | input | 2 | Lane layout select (R1) |
| sat_set | input | 1 | Turn saturation mode on |
| sat_clr | input | 1 | Turn saturation mode off |
| result | output | 32 | Registered lane results |
| lane_ovf | output | 4 | Registered per-lane clamp/wrap flags |

## Verification
The bench drives carries into every lane boundary, for example all-ones plus one in each mode. A design that leaks a carry would corrupt the neighbouring lane.

It checks that saturating and wrapping results land on the correct side for both signednesses. A design that used the sign of the result rather than the sign of the operand would clamp to the wrong limit.

It presents the absolute value of the most negative value with saturation on and with saturation off. A naive negation would return the input in both cases and never clamp.

It sends strobes in the same cycle as an operation, and sends set and clear together. A design that applied the new mode early, or let set win, would return the wrong result on the very next check.

// File: rtl/simd_alu_pkg.sv
// Shared types for the sub-word SIMD ALU.
// Assumes a 32-bit datapath built from 8-bit segments.
package simd_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MIN = 3'd2,
        OP_MAX = 3'd3,
        OP_ABS = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        LM_SINGLE = 2'd0,
        LM_DUAL   = 2'd1,
        LM_QUAD   = 2'd2
    } lane_mode_e;

endpackage

// File: rtl/simd_seg_adder.sv
// Carry-segmented adder/subtractor.
// Computes x + y, or x - y when sub is set, across NSEG segments of SEG_W bits each.
// A segment whose seg_cut bit is set starts a new lane. Its carry-in is the
// subtract carry rather than the carry out of the segment below.
// For every segment it reports the carry out of that segment's top bit and the
// signed overflow at that bit.
// Assumes seg_cut[0] is set by the caller.
module simd_seg_adder #(
    parameter int SEG_W = 8,
    parameter int NSEG  = 4,
    localparam int DW   = SEG_W * NSEG
) (
    input  logic [DW-1:0]   x,
    input  logic [DW-1:0]   y,
    input  logic            sub,
    input  logic [NSEG-1:0] seg_cut,
    output logic [DW-1:0]   sum,
    output logic [NSEG-1:0] seg_cout,
    output logic [NSEG-1:0] seg_sovf
);

    logic [DW-1:0] y_eff;
    logic [SEG_W:0] part;
    logic           carry;
    logic           cin;

    // Invert the second operand for subtraction.
    assign y_eff = sub ? ~y : y;

    // Ripple segment by segment, cutting the carry chain at lane starts.
    always_comb begin
        carry = 1'b0;
        cin   = 1'b0;
        part  = '0;
        sum   = '0;
        for (int i = 0; i < NSEG; i++) begin
            cin  = seg_cut[i] ? sub : carry;
            part = {1'b0, x[i*SEG_W +: SEG_W]} + {1'b0, y_eff[i*SEG_W +: SEG_W]}
                   + {{SEG_W{1'b0}}, cin};
            sum[i*SEG_W +: SEG_W] = part[SEG_W-1:0];
            carry       = part[SEG_W];
            seg_cout[i] = part[SEG_W];
            seg_sovf[i] = (x[i*SEG_W+SEG_W-1] == y_eff[i*SEG_W+SEG_W-1]) &&
                          (part[SEG_W-1] != x[i*SEG_W+SEG_W-1]);
        end
    end

endmodule

// File: rtl/simd_lane_ctl.sv
// Per-lane result shaping for one W-bit lane.
// Takes the lane's slice of the shared adder output and forms the final lane
// value: it saturates or wraps add and subtract, picks the operand for minimum
// and maximum, and selects the operand or its negation for absolute value.
// Assumes the adder computed a + b for add and a - b for minimum, maximum and
// subtract, and computed 0 - a for absolute value.
module simd_lane_ctl
    import simd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] sum,
    input  logic         cout,
    input  logic         sovf,
    input  alu_op_e      op,
    input  logic         sgn,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);

    localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

    logic a_lt_b;

    // Lane comparison from the subtraction result.
    assign a_lt_b = sgn ? (sum[W-1] ^ sovf) : ~cout;

    // Shape the lane result and its flag.
    always_comb begin
        res = '0;
        ovf = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                if (sgn) begin
                    ovf = sovf;
                    res = (sat && sovf) ? (a[W-1] ? NEG_LIM : POS_LIM) : sum;
                end else if (op == OP_ADD) begin
                    ovf = cout;
                    res = (sat && cout) ? '1 : sum;
                end else begin
                    ovf = ~cout;
                    res = (sat && !cout) ? '0 : sum;
                end
            end
            OP_MIN:  res = a_lt_b ? a : b;
            OP_MAX:  res = a_lt_b ? b : a;
            OP_ABS: begin
                ovf = sovf;
                res = a[W-1] ? ((sat && sovf) ? POS_LIM : sum) : a;
            end
            default: begin
                res = '0;
                ovf = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/simd_sat_alu.sv
// Sub-word SIMD ALU with a persistent saturation mode.
// Splits 32-bit operands into 1, 2 or 4 lanes and runs add, subtract, minimum,
// maximum or absolute value on every lane through one segmented adder.
// It registers the result and the per-lane flags with one cycle of latency.
// Assumes DATA_W / SEG_W == 4, so that the three lane layouts exist.
module simd_sat_alu
    import simd_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEG_W  = 8,
    localparam int NSEG  = DATA_W / SEG_W,
    localparam int NLAY  = $clog2(NSEG) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [2:0]        opcode,
    input  logic              is_signed,
    input  logic [1:0]        lane_mode,
    input  logic              sat_set,
    input  logic              sat_clr,
    output logic [DATA_W-1:0] result,
    output logic [NSEG-1:0]   lane_ovf
);

    alu_op_e            op;
    logic               sat_q;
    logic [1:0]         lay_sel;
    logic [NSEG-1:0]    seg_cut;
    logic [DATA_W-1:0]  add_x, add_y, add_sum;
    logic               add_sub;
    logic [NSEG-1:0]    seg_cout, seg_sovf;
    logic [DATA_W-1:0]  lay_res [NLAY];
    logic [NSEG-1:0]    lay_ovf [NLAY];

    assign op = alu_op_e'(opcode);

    // Map the lane-mode code to a layout index; code 3 falls back to single.
    always_comb begin
        case (lane_mode)
            LM_DUAL: lay_sel = 2'd1;
            LM_QUAD: lay_sel = 2'd2;
            default: lay_sel = 2'd0;
        endcase
    end

    // Mark the segments that start a lane in the selected layout.
    always_comb begin
        for (int i = 0; i < NSEG; i++)
            seg_cut[i] = ((i % (NSEG >> lay_sel)) == 0);
    end

    // Steer the adder operands: 0 - a for absolute value, a +/- b otherwise.
    always_comb begin
        add_x   = (op == OP_ABS) ? '0 : src_a;
        add_y   = (op == OP_ABS) ? src_a : src_b;
        add_sub = (op != OP_ADD);
    end

    simd_seg_adder #(.SEG_W(SEG_W), .NSEG(NSEG)) u_adder (
        .x(add_x), .y(add_y), .sub(add_sub), .seg_cut(seg_cut),
        .sum(add_sum), .seg_cout(seg_cout), .seg_sovf(seg_sovf)
    );

    // One bank of lane controllers per layout; lane j takes its top-segment flags.
    for (genvar g = 0; g < NLAY; g++) begin : g_lay
        localparam int LW  = DATA_W >> g;
        localparam int NL  = 1 << g;
        localparam int SPL = LW / SEG_W;
        for (genvar j = 0; j < NSEG; j++) begin : g_lane
            if (j < NL) begin : g_on
                simd_lane_ctl #(.W(LW)) u_lane (
                    .a(src_a[j*LW +: LW]), .b(src_b[j*LW +: LW]),
                    .sum(add_sum[j*LW +: LW]),
                    .cout(seg_cout[(j+1)*SPL-1]), .sovf(seg_sovf[(j+1)*SPL-1]),
                    .op(op), .sgn(is_signed), .sat(sat_q),
                    .res(lay_res[g][j*LW +: LW]), .ovf(lay_ovf[g][j])
                );
            end else begin : g_off
                assign lay_ovf[g][j] = 1'b0;
            end
        end
    end

    // Saturation mode register: clear takes priority over set.
    always_ff @(posedge clk) begin
        if (!rst_n)       sat_q <= 1'b0;
        else if (sat_clr) sat_q <= 1'b0;
        else if (sat_set) sat_q <= 1'b1;
    end

    // Output register for the selected layout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            lane_ovf <= '0;
        end else begin
            result   <= lay_res[lay_sel];
            lane_ovf <= lay_ovf[lay_sel];
        end
    end

    // R9: reset clears outputs and mode
    a_r9_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && lane_ovf == '0 && !sat_q));

    // R6: set without clear turns the mode on
    a_r6_sat_set: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_set && !sat_clr) |=> sat_q);

    // R6: clear always wins
    a_r6_sat_clr: assert property (@(posedge clk) disable iff (!rst_n)
        sat_clr |=> !sat_q);

    // R6: mode holds without strobes
    a_r6_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_set && !sat_clr) |=> $stable(sat_q));

    // R5: minimum and maximum never flag
    a_r5_minmax_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MIN || op == OP_MAX) |=> lane_ovf == '0);

    // R7: absent lanes read zero
    a_r7_single_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode == LM_SINGLE || lane_mode == 2'd3) |=> lane_ovf[NSEG-1:1] == '0);

    a_r7_dual_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_mode == LM_DUAL) |=> lane_ovf[NSEG-1:2] == '0);

    // R2: undefined opcodes give zero
    a_r2_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode > 3'd4) |=> (result == '0 && lane_ovf == '0));

endmodule

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] src_a, src_b;
    logic [2:0]  opcode;
    logic        is_signed;
    logic [1:0]  lane_mode;
    logic        sat_set, sat_clr;
    logic [31:0] result;
    logic [3:0]  lane_ovf;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_sat = 0;

    always #4 clk = ~clk;

    simd_sat_alu u_dut (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .opcode(opcode), .is_signed(is_signed), .lane_mode(lane_mode),
        .sat_set(sat_set), .sat_clr(sat_clr),
        .result(result), .lane_ovf(lane_ovf)
    );

    // Behavioural reference: returns {flags, result}.
    function automatic logic [35:0] model(logic [31:0] a, logic [31:0] b,
                                          int op, bit sg, int lm, bit sat);
        int w;
        int n;
        logic [31:0] r;
        logic [3:0]  f;
        w = (lm == 1) ? 16 : (lm == 2) ? 8 : 32;
        n = 32 / w;
        r = '0;
        f = '0;
        for (int j = 0; j < n; j++) begin
            longint mask, half, av, bv, sa, sb, rv;
            bit o;
            mask = (longint'(1) << w) - 1;
            half = longint'(1) << (w - 1);
            av = longint'(a >> (j * w)) & mask;
            bv = longint'(b >> (j * w)) & mask;
            sa = (av >= half) ? av - (mask + 1) : av;
            sb = (bv >= half) ? bv - (mask + 1) : bv;
            o  = 0;
            rv = 0;
            case (op)
                0, 1: begin
                    if (sg) begin
                        rv = (op == 0) ? sa + sb : sa - sb;
                        if (rv > half - 1) begin o = 1; if (sat) rv = half - 1; end
                        else if (rv < -half) begin o = 1; if (sat) rv = -half; end
                    end else if (op == 0) begin
                        rv = av + bv;
                        if (rv > mask) begin o = 1; if (sat) rv = mask; end
                    end else begin
                        rv = av - bv;
                        if (rv < 0) begin o = 1; if (sat) rv = 0; end
                    end
                end
                2: rv = sg ? ((sa < sb) ? sa : sb) : ((av < bv) ? av : bv);
                3: rv = sg ? ((sa < sb) ? sb : sa) : ((av < bv) ? bv : av);
                4: begin
                    rv = (sa < 0) ? -sa : sa;
                    if (rv > half - 1) begin o = 1; rv = sat ? half - 1 : sa; end
                end
                default: rv = 0;
            endcase
            r = r | (32'(rv & mask) << (j * w));
            f[j] = o;
        end
        return {f, r};
    endfunction

    // Present one operation at a negedge; check after the next posedge.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input int op,
                          input bit sg, input int lm, input bit set, input bit clr,
                          input string tag);
        logic [35:0] exp;
        exp = model(a, b, op, sg, lm, model_sat);
        src_a = a; src_b = b; opcode = 3'(op); is_signed = sg;
        lane_mode = 2'(lm); sat_set = set; sat_clr = clr;
        if (clr) model_sat = 0;
        else if (set) model_sat = 1;
        @(posedge clk);
        #2;
        checks++;
        if (result !== exp[31:0] || lane_ovf !== exp[35:32]) begin
            failures++;
            $display("FAIL %s: op=%0d a=%h b=%h got res=%h ovf=%b expected res=%h ovf=%b",
                     tag, op, a, b, result, lane_ovf, exp[31:0], exp[35:32]);
        end
        @(negedge clk);
        sat_set = 0; sat_clr = 0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: expired, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 0; src_a = '1; src_b = '1; opcode = 0; is_signed = 0;
        lane_mode = 0; sat_set = 1; sat_clr = 0;
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (result !== 32'h0 || lane_ovf !== 4'h0) begin
            failures++;
            $display("FAIL R9 reset: got res=%h ovf=%b expected res=0 ovf=0", result, lane_ovf);
        end
        @(negedge clk);
        rst_n = 1; sat_set = 0;

        // R9: saturation is off after reset, so this wraps
        run_op(32'h000000FF, 32'h00000001, 0, 0, 2, 0, 0, "R9 sat off after reset");
        // R1: carries stay inside lanes
        run_op(32'hFFFFFFFF, 32'h01010101, 0, 0, 2, 0, 0, "R1 quad carry cut");
        run_op(32'h0000FFFF, 32'h00000001, 0, 0, 1, 0, 0, "R1 dual carry cut");
        run_op(32'h0000FFFF, 32'h00000001, 0, 0, 0, 0, 0, "R1 single carry");
        run_op(32'h00000000, 32'h00010001, 1, 0, 1, 0, 0, "R1 dual borrow cut");
        run_op(32'h0000FFFF, 32'h00000001, 0, 0, 3, 0, 0, "R1 mode 3 as single");
        // R2: wrapping and undefined opcodes
        run_op(32'h80000000, 32'h00010001, 1, 1, 1, 0, 0, "R2 signed sub wrap");
        run_op(32'h7F7F7F7F, 32'h01010101, 0, 1, 2, 0, 0, "R2 signed add wrap");
        run_op(32'h12345678, 32'h9ABCDEF0, 5, 1, 2, 0, 0, "R2 opcode 5 zero");
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 7, 0, 0, 0, 0, "R2 opcode 7 zero");
        // R6: the op in the strobe cycle uses the old mode
        run_op(32'hFFFFFFFF, 32'h01010101, 0, 0, 2, 1, 0, "R6 set same cycle old mode");
        run_op(32'hFFFFFFFF, 32'h01010101, 0, 0, 2, 0, 0, "R6 mode now on");
        // R3: signed clamps
        run_op(32'h7FFF8000, 32'h00018000, 0, 1, 1, 0, 0, "R3 signed add clamp");
        run_op(32'h80007FFF, 32'h0001FFFF, 1, 1, 1, 0, 0, "R3 signed sub clamp");
        run_op(32'h7FFFFFFF, 32'h00000001, 0, 1, 0, 0, 0, "R3 single clamp");
        // R4: unsigned clamps
        run_op(32'hF0100000, 32'h20F00000, 0, 0, 2, 0, 0, "R4 unsigned add clamp");
        run_op(32'h0005FF00, 32'h00100001, 1, 0, 1, 0, 0, "R4 unsigned sub clamp");
        // R5: comparisons
        run_op(32'h80017F00, 32'h01800080, 2, 1, 2, 0, 0, "R5 signed min");
        run_op(32'h80017F00, 32'h01800080, 2, 0, 2, 0, 0, "R5 unsigned min");
        run_op(32'h80017F00, 32'h01800080, 3, 1, 2, 0, 0, "R5 signed max");
        run_op(32'h80008000, 32'h7FFF0001, 3, 0, 1, 0, 0, "R5 unsigned max");
        // R8: absolute value with saturation on
        run_op(32'h80FF7F01, 32'hFFFFFFFF, 4, 0, 2, 0, 0, "R8 abs sat on");
        run_op(32'h80000000, 32'h00000000, 4, 1, 0, 0, 0, "R8 abs single sat on");
        // R6: set and clear together leave the mode off
        run_op(32'h00000000, 32'h00000000, 0, 0, 0, 1, 1, "R6 clear wins strobe cycle");
        run_op(32'hFFFFFFFF, 32'h01010101, 0, 0, 2, 0, 0, "R6 clear wins");
        // R8: absolute value with saturation off
        run_op(32'h80FF7F01, 32'h00000000, 4, 1, 2, 0, 0, "R8 abs sat off");
        run_op(32'h80008001, 32'h00000000, 4, 0, 1, 0, 0, "R8 abs dual sat off");
        // R7: flags per lane in each layout
        run_op(32'h7FFF0001, 32'h7FFF0001, 0, 1, 1, 0, 0, "R7 dual flag lane1");
        run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 0, 0, 0, 0, 0, "R7 single flag");

        // Mixed random traffic with occasional mode strobes (R1-R8 model)
        for (int k = 0; k < 600; k++) begin
            logic [31:0] ra, rb;
            int rop, rlm;
            bit rs, rset, rclr;
            ra = $urandom;
            rb = $urandom;
            if (k % 7 == 0) ra = 32'h80808080;
            if (k % 11 == 0) rb = 32'h7F7F7F7F;
            rop  = $urandom_range(0, 5);
            rlm  = $urandom_range(0, 3);
            rs   = 1'($urandom_range(0, 1));
            rset = ($urandom_range(0, 9) == 0);
            rclr = ($urandom_range(0, 9) == 0);
            run_op(ra, rb, rop, rs, rlm, rset, rclr, "R7 random mix");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule